// File: doc/BRIEF.md
# Audio Stream DMA Channel

This block is one direction of a DMA engine that carries audio samples between system memory and a codec-side byte stream. Build it once with `CAPTURE = 0` for playback, where it reads memory and hands words to the audio side. Build it again with `CAPTURE = 1` for capture, where it takes words from the audio side and writes them to memory. Software sets up three words through a small register port: an enable flag, a byte address and a byte count still to move.

When the audio side wants service, it pulses a request carrying the number of bytes it can supply or take. The channel moves the smaller of that figure and the outstanding count, one 32-bit word per handshake. After each word it steps the address forward and the count down. The audio side may refuse a word part way through. The channel then stops, and the registers show only the words that really moved. If the count reaches zero through a transfer while the channel is enabled, a one-cycle completion pulse is raised.

Top module: `audio_dma_channel`

## Requirements
- R1: After reset, enable, address and remaining count all read 0. `svc_busy`, `mem_req`, `aud_stb`, `stream_en` and `done_irq` are all low.
- R2: Register select 0 is control, with the enable flag in bit 0 and all other bits reading 0. Select 1 is the byte address and select 2 is the remaining byte count. `sw_rdata` shows the selected word one clock after `sw_sel` is presented. `stream_en` follows the enable flag.
- R3: A service request moves min(remaining count, `svc_bytes`) bytes as 4-byte words, with one memory handshake and one audio handshake per word.
- R4: Each completed word adds 4 to the address register and subtracts 4 from the remaining count.
- R5: A service request whose computed length is zero changes no register, starts no handshake and raises no completion pulse.
- R6: `done_irq` is high for exactly one cycle after a transfer that leaves the count at zero while enable is 1. A transfer made while enable is 0 still moves data but raises no pulse.
- R7: `aud_nak` ends the transfer at once. The word it refused is not counted, and no pulse is raised unless the count is zero.
- R8: In playback, each word is fetched from memory at the current address before it is offered on `aud_wdata`. `mem_req` and `mem_addr` hold steady until `mem_ack`, and `mem_we` is 0.
- R9: In capture, each word is first taken from `aud_rdata` and then written to memory at the current address with `mem_we` = 1.
- R10: While `svc_busy` is high, new service requests are ignored and software writes to the address and count are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select (0 control, 1 address, 2 count) |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Registered read data of selected word |
| svc_req | input | 1 | Service request pulse from audio side |
| svc_bytes | input | SVC_W | Bytes the audio side can supply or accept |
| svc_busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write (capture), 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory handshake complete |
| aud_stb | output | 1 | Audio word handshake strobe |
| aud_wdata | output | 32 | Word to audio side (playback) |
| aud_rdata | input | 32 | Word from audio side (capture), valid with ack |
| aud_ack | input | 1 | Audio side took or gave the word |
| aud_nak | input | 1 | Audio side has no more room or data |
| stream_en | output | 1 | Enable flag, activates the audio stream |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a refusal from the audio side in the middle of a multi-word burst. By that point a memory fetch has already happened for the refused word, yet the address and count must still match only the words that were accepted. The bench audio model therefore takes a set number of words and then answers with a refusal. The vector table mixes these limits with count-bound and request-bound lengths, zero lengths and the disabled case. A directed test writes registers and sends a second request while a long burst is running, and then checks that neither had any effect.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_AUD  = 2'd2,
    ST_FIN  = 2'd3
  } dma_state_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_REM  = 2'd2;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              busy,
  input  logic              adv,
  output logic              en_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  rem_q
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(DATA_W / 8);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(DATA_W / 8);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      sw_rdata <= '0;
    end else begin
      if (sw_we && sw_sel == SEL_CTRL) en_q <= sw_wdata[0];
      if (adv) begin
        addr_q <= addr_q + ADDR_STEP;
        rem_q  <= rem_q - CNT_STEP;
      end else if (sw_we && !busy) begin
        if (sw_sel == SEL_ADDR) addr_q <= sw_wdata[ADDR_W-1:0];
        if (sw_sel == SEL_REM)  rem_q  <= sw_wdata[CNT_W-1:0];
      end
      case (sw_sel)
        SEL_CTRL: sw_rdata <= {31'd0, en_q};
        SEL_ADDR: sw_rdata <= 32'(addr_q);
        SEL_REM:  sw_rdata <= 32'(rem_q);
        default:  sw_rdata <= '0;
      endcase
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !adv) |=> ($stable(addr_q) && $stable(rem_q))); // R10
  AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    adv |-> busy); // R4
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter bit CAPTURE = 1'b0,
  parameter int CNT_W   = 24,
  parameter int SVC_W   = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  rem,
  input  logic              svc_req,
  input  logic [SVC_W-1:0]  svc_bytes,
  output logic              busy,
  output logic              adv,
  output logic              mem_req,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              aud_stb,
  input  logic [DATA_W-1:0] aud_rdata,
  input  logic              aud_ack,
  input  logic              aud_nak,
  output logic [DATA_W-1:0] word_q,
  output logic              irq_q
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(DATA_W / 8);
  localparam dma_state_t FIRST = CAPTURE ? ST_AUD : ST_MEM;

  dma_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  svc_ext;
  logic [CNT_W-1:0]  len;
  logic              buf_ld;
  logic              last_word;

  assign svc_ext   = CNT_W'(svc_bytes);
  assign len       = (svc_ext < rem) ? svc_ext : rem;
  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_MEM);
  assign aud_stb   = (state == ST_AUD);
  assign last_word = (cnt <= STEP);

  generate
    if (CAPTURE) begin : g_cap
      assign adv    = (state == ST_MEM) && mem_ack;
      assign buf_ld = (state == ST_AUD) && aud_ack;
    end else begin : g_play
      assign adv    = (state == ST_AUD) && aud_ack;
      assign buf_ld = (state == ST_MEM) && mem_ack;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      word_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (buf_ld) word_q <= CAPTURE ? aud_rdata : mem_rdata;
      case (state)
        ST_IDLE: begin
          if (svc_req && len != '0) begin
            cnt   <= len;
            state <= FIRST;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            if (CAPTURE) begin
              cnt   <= cnt - STEP;
              state <= last_word ? ST_FIN : ST_AUD;
            end else begin
              state <= ST_AUD;
            end
          end
        end
        ST_AUD: begin
          if (aud_ack) begin
            if (CAPTURE) begin
              state <= ST_MEM;
            end else begin
              cnt   <= cnt - STEP;
              state <= last_word ? ST_FIN : ST_MEM;
            end
          end else if (aud_nak) begin
            state <= ST_FIN;
          end
        end
        default: begin
          irq_q <= en && (rem == '0);
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && svc_req && (svc_bytes == '0 || rem == '0)) |=> !busy); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R6
  AST_IRQ_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (en && rem == '0 && !busy)); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req); // R8
  AST_CNT_FITS: assert property (@(posedge clk) disable iff (rst)
    (busy && state != ST_FIN) |-> (cnt != '0 && cnt <= rem)); // R3
endmodule

// File: rtl/audio_dma_channel.sv
module audio_dma_channel
  import dmach_pkg::*;
#(
  parameter bit CAPTURE = 1'b0,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 24,
  parameter int SVC_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  input  logic              svc_req,
  input  logic [SVC_W-1:0]  svc_bytes,
  output logic              svc_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              aud_stb,
  output logic [31:0]       aud_wdata,
  input  logic [31:0]       aud_rdata,
  input  logic              aud_ack,
  input  logic              aud_nak,
  output logic              stream_en,
  output logic              done_irq
);
  localparam int DATA_W = 32;

  logic              adv;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] word_q;

  dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .busy(svc_busy), .adv(adv), .en_q(en_q),
    .addr_q(addr_q), .rem_q(rem_q)
  );

  dmach_engine #(.CAPTURE(CAPTURE), .CNT_W(CNT_W), .SVC_W(SVC_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .en(en_q), .rem(rem_q), .svc_req(svc_req),
    .svc_bytes(svc_bytes), .busy(svc_busy), .adv(adv), .mem_req(mem_req),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .aud_stb(aud_stb),
    .aud_rdata(aud_rdata), .aud_ack(aud_ack), .aud_nak(aud_nak),
    .word_q(word_q), .irq_q(done_irq)
  );

  assign mem_we    = CAPTURE;
  assign mem_addr  = addr_q;
  assign mem_wdata = word_q;
  assign aud_wdata = word_q;
  assign stream_en = en_q;

  AST_WE_FIXED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_we == CAPTURE)); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> $stable(mem_addr)); // R8
endmodule

// File: tb/tb_audio_dma_channel.sv
`timescale 1ns/1ps
module tb_audio_dma_channel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // playback instance signals
  logic        sw_we = 0;
  logic [1:0]  sw_sel = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] sw_rdata;
  logic        svc_req = 0;
  logic [15:0] svc_bytes = 0;
  logic        svc_busy, mem_req, mem_we, aud_stb, stream_en, done_irq;
  logic [31:0] mem_addr, mem_wdata, aud_wdata;
  logic [31:0] mem_rdata = 0;
  logic        mem_ack = 0, aud_ack = 0, aud_nak = 0;

  audio_dma_channel #(.CAPTURE(1'b0)) dut (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .svc_req(svc_req), .svc_bytes(svc_bytes), .svc_busy(svc_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .aud_stb(aud_stb), .aud_wdata(aud_wdata),
    .aud_rdata(32'd0), .aud_ack(aud_ack), .aud_nak(aud_nak), .stream_en(stream_en),
    .done_irq(done_irq)
  );

  // capture instance signals
  logic        c_we = 0;
  logic [1:0]  c_sel = 0;
  logic [31:0] c_wdata = 0;
  logic [31:0] c_rdata;
  logic        c_req = 0;
  logic [15:0] c_bytes = 0;
  logic        c_busy, c_mreq, c_mwe, c_astb, c_sen, c_irq;
  logic [31:0] c_maddr, c_mwdata, c_awdata;
  logic        c_mack = 0, c_aack = 0;
  logic [31:0] c_ardata = 0;

  audio_dma_channel #(.CAPTURE(1'b1)) dut_cap (
    .clk(clk), .rst(rst), .sw_we(c_we), .sw_sel(c_sel), .sw_wdata(c_wdata),
    .sw_rdata(c_rdata), .svc_req(c_req), .svc_bytes(c_bytes), .svc_busy(c_busy),
    .mem_req(c_mreq), .mem_we(c_mwe), .mem_addr(c_maddr), .mem_wdata(c_mwdata),
    .mem_rdata(32'd0), .mem_ack(c_mack), .aud_stb(c_astb), .aud_wdata(c_awdata),
    .aud_rdata(c_ardata), .aud_ack(c_aack), .aud_nak(1'b0), .stream_en(c_sen),
    .done_irq(c_irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  // memory and audio models for playback, driven at the falling edge
  int aud_limit = 1000;
  int taken = 0;
  int irq_seen = 0;
  logic [31:0] log_w [64];
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   = 1'b1;
      mem_rdata = pat(mem_addr);
    end else mem_ack = 1'b0;
    if (aud_stb && !aud_ack && !aud_nak) begin
      if (taken < aud_limit) begin
        aud_ack = 1'b1;
        if (taken < 64) log_w[taken] = aud_wdata;
        taken++;
      end else aud_nak = 1'b1;
    end else begin
      aud_ack = 1'b0;
      aud_nak = 1'b0;
    end
    if (done_irq) irq_seen++;
  end

  // models for capture
  int c_src = 0, c_nw = 0, c_irqs = 0;
  logic [31:0] c_waddr [8];
  logic [31:0] c_wdat [8];
  logic        c_wwe [8];
  always @(negedge clk) begin
    if (c_mreq && !c_mack) begin
      c_mack = 1'b1;
      if (c_nw < 8) begin
        c_waddr[c_nw] = c_maddr; c_wdat[c_nw] = c_mwdata; c_wwe[c_nw] = c_mwe;
      end
      c_nw++;
    end else c_mack = 1'b0;
    if (c_astb && !c_aack) begin
      c_aack = 1'b1;
      c_ardata = 32'h5000_0000 + 32'(c_src);
      c_src++;
    end else c_aack = 1'b0;
    if (c_irq) c_irqs++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_sel = s; sw_wdata = d;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); sw_sel = s;
    @(negedge clk); d = sw_rdata;
  endtask

  task automatic pulse_svc(input logic [15:0] b);
    @(negedge clk); svc_req = 1'b1; svc_bytes = b;
    @(negedge clk); svc_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (svc_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic        en;
    logic [31:0] addr;
    logic [23:0] rem;
    logic [15:0] svc;
    logic [7:0]  lim;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t TABLE [NROWS] = '{
    '{1'b1, 32'h100, 24'd16, 16'd64, 8'd99},  // count-bound, completes (R6)
    '{1'b1, 32'h200, 24'd64, 16'd16, 8'd99},  // request-bound, count left
    '{1'b0, 32'h300, 24'd8,  16'd8,  8'd99},  // disabled, no pulse
    '{1'b1, 32'h400, 24'd32, 16'd32, 8'd3},   // refusal after 3 words (R7)
    '{1'b1, 32'h500, 24'd0,  16'd32, 8'd99},  // zero count (R5)
    '{1'b1, 32'h600, 24'd16, 16'd0,  8'd99},  // zero request (R5)
    '{1'b1, 32'h700, 24'd4,  16'd4,  8'd99},  // single word
    '{1'b1, 32'h800, 24'd8,  16'd8,  8'd0}    // refused at once (R7)
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(svc_busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 aud_stb", 32'(aud_stb), 0);
    chk("R1 stream_en", 32'(stream_en), 0);
    chk("R1 done_irq", 32'(done_irq), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 addr", v, 0);
    rd(2'd2, v); chk("R1 count", v, 0);

    // R2 register access
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 ctrl only bit0", v, 32'd1);
    chk("R2 stream_en", 32'(stream_en), 1);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, v); chk("R2 addr", v, 32'h1234_5678);
    wr(2'd2, 32'h0000_0ABC);
    rd(2'd2, v); chk("R2 count", v, 32'h0000_0ABC);
    wr(2'd0, 32'h0);
    chk("R2 stream_en off", 32'(stream_en), 0);
    chk("R8 mem_we playback", 32'(mem_we), 0);

    // vector table: R3 R4 R5 R6 R7 R8
    for (int r = 0; r < NROWS; r++) begin
      int mv, wl;
      logic [31:0] exp_irq;
      mv = int'(TABLE[r].rem);
      if (int'(TABLE[r].svc) < mv) mv = int'(TABLE[r].svc);
      wl = int'(TABLE[r].lim) * 4;
      if (wl < mv) mv = wl;
      exp_irq = (TABLE[r].en && mv > 0 && int'(TABLE[r].rem) == mv) ? 1 : 0;
      wr(2'd0, {31'd0, TABLE[r].en});
      wr(2'd1, TABLE[r].addr);
      wr(2'd2, {8'd0, TABLE[r].rem});
      taken = 0; irq_seen = 0; aud_limit = int'(TABLE[r].lim);
      pulse_svc(TABLE[r].svc);
      wait_idle();
      chk("R3 words moved", 32'(taken), 32'(mv / 4));
      rd(2'd1, v); chk("R4 addr advance", v, TABLE[r].addr + 32'(mv));
      rd(2'd2, v); chk("R4 count decrease", v, 32'(TABLE[r].rem) - 32'(mv));
      chk("R6 R7 R5 completion pulses", 32'(irq_seen), exp_irq);
      for (int i = 0; i < taken && i < 64; i++)
        chk("R8 playback data", log_w[i], pat(TABLE[r].addr + 32'(4 * i)));
    end

    // R10 writes and requests during a busy transfer are dropped
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h900);
    wr(2'd2, 32'd64);
    taken = 0; irq_seen = 0; aud_limit = 1000;
    pulse_svc(16'd64);
    @(negedge clk);
    chk("R10 busy mid burst", 32'(svc_busy), 1);
    @(negedge clk); sw_we = 1'b1; sw_sel = 2'd1; sw_wdata = 32'h0000_1234;
    @(negedge clk); sw_sel = 2'd2; sw_wdata = 32'd4;
    @(negedge clk); sw_we = 1'b0; svc_req = 1'b1; svc_bytes = 16'd4;
    @(negedge clk); svc_req = 1'b0;
    wait_idle();
    chk("R10 words", 32'(taken), 32'd16);
    rd(2'd1, v); chk("R10 addr kept", v, 32'h940);
    rd(2'd2, v); chk("R10 count kept", v, 32'd0);
    chk("R10 R6 single pulse", 32'(irq_seen), 32'd1);

    // R9 capture direction
    @(negedge clk); c_we = 1'b1; c_sel = 2'd0; c_wdata = 32'd1;
    @(negedge clk); c_sel = 2'd1; c_wdata = 32'hA00;
    @(negedge clk); c_sel = 2'd2; c_wdata = 32'd8;
    @(negedge clk); c_we = 1'b0; c_req = 1'b1; c_bytes = 16'd100;
    @(negedge clk); c_req = 1'b0;
    @(negedge clk);
    while (c_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R9 capture writes", 32'(c_nw), 32'd2);
    chk("R9 write addr0", c_waddr[0], 32'hA00);
    chk("R9 write data0", c_wdat[0], 32'h5000_0000);
    chk("R9 write addr1", c_waddr[1], 32'hA04);
    chk("R9 write data1", c_wdat[1], 32'h5000_0001);
    chk("R9 write enable", 32'(c_wwe[0] & c_wwe[1]), 32'd1);
    chk("R9 R6 capture pulse", 32'(c_irqs), 32'd1);
    @(negedge clk); c_sel = 2'd1;
    @(negedge clk); chk("R9 R4 capture addr", c_rdata, 32'hA08);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule